// File: doc/BRIEF.md
# Sample-and-Hold Bank Refresh Sequencer

This controller keeps a bank of analog sample-and-hold channels topped up from one shared DAC. A host writes a digital code for every channel into a small register file. The sequencer then visits the channels one by one. For each channel it loads that channel's code into the DAC and drives the channel address. It waits until both the address and the DAC output have settled, then pulls an active-low sample strobe low long enough for the hold capacitor to acquire the value. It releases the strobe and keeps the address steady for a while before it moves to the next channel.

There are two build variants. A single bank has 32 channels. A dual bank has 64 channels: two 32-channel devices share the five address lines and the strobe, and the select line tells them apart. Every timing limit is given in nanoseconds together with the clock rate, and the block turns each one into a whole number of cycles, always rounding up. Droop in the held voltages sets a deadline, so the whole sweep repeats on a fixed refresh period.

Top module: `shr_refresh_seq`

## Requirements
- R1: While reset is asserted, `sample_n` is 1 (all channels hold), `bank_sel` is 0, and `busy`, `dac_load` and `sweep_done` are 0.
- R2: A sweep visits channels 0 to N-1 in ascending order, one DAC load each. `ch_addr` carries channel bits 4:0. In dual-bank mode `bank_sel` carries channel bit 5, so channels 32 to 63 drive it high. In single-bank mode `bank_sel` is driven high during sweeps.
- R3: `ch_addr` and `bank_sel` are stable for at least ceil(SETUP_NS·f) cycles before `sample_n` falls.
- R4: `sample_n` stays low for at least ceil(SAMPLE_NS·f) cycles per visit.
- R5: `ch_addr` and `bank_sel` change only while `sample_n` is high, and only after it has been high for at least ceil(HOLD_NS·f) cycles.
- R6: Between two low strobe pulses, `sample_n` stays high for at least ceil(GAP_NS·f) cycles.
- R7: `dac_load` is a one-cycle pulse that occurs at least ceil(SETTLE_NS·f) cycles before `sample_n` falls. While `sample_n` is low, there is no load and `dac_code` does not change.
- R8: The code sent to the DAC for a channel is that channel's register value when the channel is loaded. A write made between sweeps takes effect on the next visit.
- R9: A write to the channel that is currently sampling is parked and committed once the strobe rises. If several such writes arrive, the last one wins. The channel's next visit then carries the last written code.
- R10: Sweep starts are REFRESH_NS·f cycles apart when a sweep fits in the period. `busy` is high for the whole sweep. `sweep_done` is a one-cycle pulse that comes with `busy` falling after the last channel.
- R11: The first sweep begins on the first clock edge after reset is released, with a DAC load for channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe for a channel code |
| wr_chan | input | ADDR_W+DUAL_BANK | Channel index being written |
| wr_code | input | DAC_W | Code to store for that channel |
| dac_code | output | DAC_W | Parallel code for the DAC |
| dac_load | output | 1 | One-cycle DAC load pulse |
| ch_addr | output | ADDR_W | Channel address shared by both banks |
| bank_sel | output | 1 | Bank select (channel bit 5 in dual-bank mode) |
| sample_n | output | 1 | Sample strobe, low = addressed channel samples |
| busy | output | 1 | Sweep in progress |
| sweep_done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The bench watches every strobe edge and every address change and measures the four timing gaps in cycles. A sequencer that got its count off by one, or that moved the address while the strobe was low, would fail these checks on the first channel. The bench checks the step from channel 31 to channel 32 to show that `bank_sel` flips and the low address bits wrap; a design that dropped bit 5 would present the same channel twice. A double write aimed at a channel while it samples must appear, last value wins, on the following sweep; a design that lost parked writes, or kept the first one, would show a stale code. The bench also times the period between sweep starts exactly, to catch a timer that restarts at the end of a sweep instead of at its start.

// File: rtl/shr_pkg.sv
package shr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SAMPLE,
        ST_HOLD
    } shr_state_e;

    // Nanoseconds to clock cycles at clk_khz, rounded up, never below one.
    function automatic int ns2cyc(input int ns, input int clk_khz);
        longint prod;
        longint cyc;
        prod = longint'(ns) * longint'(clk_khz);
        cyc  = (prod + 64'sd999999) / 64'sd1000000;
        return (cyc < 1) ? 1 : int'(cyc);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/shr_regfile.sv
module shr_regfile #(
    parameter int NCH   = 64,
    parameter int CH_W  = 6,
    parameter int DAC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic [DAC_W-1:0] wr_code,
    input  logic             lock_en,
    input  logic [CH_W-1:0]  lock_chan,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [DAC_W-1:0] rd_code
);

    typedef struct packed {
        logic             pend_v;
        logic [CH_W-1:0]  pend_chan;
        logic [DAC_W-1:0] pend_code;
    } park_t;

    park_t            park_d, park_q;
    logic [DAC_W-1:0] mem_d [NCH];
    logic [DAC_W-1:0] mem_q [NCH];

    always_comb begin
        park_d = park_q;
        mem_d  = mem_q;
        // commit the parked write once the strobe has gone back to hold
        if (park_q.pend_v && !lock_en) begin
            mem_d[park_q.pend_chan] = park_q.pend_code;
            park_d.pend_v           = 1'b0;
        end
        if (wr_en) begin
            if (lock_en && (wr_chan == lock_chan)) begin
                park_d.pend_v    = 1'b1;
                park_d.pend_chan = wr_chan;
                park_d.pend_code = wr_code;
            end else begin
                mem_d[wr_chan] = wr_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            park_q <= '0;
            for (int i = 0; i < NCH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            park_q <= park_d;
            mem_q  <= mem_d;
        end
    end

    assign rd_code = mem_q[rd_chan];

endmodule

// File: rtl/shr_period_timer.sv
module shr_period_timer #(
    parameter int PERIOD_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);

    localparam int CW = $clog2(PERIOD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // reset to the expired value so the first sweep starts at once
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= LAST;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == LAST);

endmodule

// File: rtl/shr_sequencer.sv
module shr_sequencer
    import shr_pkg::*;
#(
    parameter int NCH        = 64,
    parameter int CH_W       = 6,
    parameter int ADDR_W     = 5,
    parameter int DAC_W      = 8,
    parameter int DUAL_BANK  = 1,
    parameter int WAIT_CYC   = 13,
    parameter int SAMPLE_CYC = 500,
    parameter int HOLD_CYC   = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              expired,
    input  logic [DAC_W-1:0]  rd_code,
    output logic [CH_W-1:0]   rd_chan,
    output logic              restart,
    output logic              lock_en,
    output logic [CH_W-1:0]   lock_chan,
    output logic [DAC_W-1:0]  dac_code,
    output logic              dac_load,
    output logic [ADDR_W-1:0] ch_addr,
    output logic              bank_sel,
    output logic              sample_n,
    output logic              busy,
    output logic              sweep_done
);

    localparam int CNT_MAX = max2(max2(WAIT_CYC, SAMPLE_CYC), HOLD_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CH_W-1:0]  LAST_CH    = CH_W'(NCH - 1);
    localparam logic [CNT_W-1:0] WAIT_LD    = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] SAMPLE_LD  = CNT_W'(SAMPLE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD    = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        shr_state_e       state;
        logic [CH_W-1:0]  ch;
        logic [CNT_W-1:0] cnt;
        logic [DAC_W-1:0] code;
        logic             load;
        logic             strobe_n;
        logic             sel;
        logic             busy;
        logic             done;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state:    ST_IDLE,
        ch:       '0,
        cnt:      '0,
        code:     '0,
        load:     1'b0,
        strobe_n: 1'b1,
        sel:      1'b0,
        busy:     1'b0,
        done:     1'b0
    };

    seq_t            seq_d, seq_q;
    logic [CH_W-1:0] nxt_ch;
    logic            nxt_sel;

    assign nxt_ch = (seq_q.state == ST_IDLE) ? '0 : seq_q.ch + 1'b1;

    generate
        if (DUAL_BANK != 0) begin : g_dual
            assign nxt_sel = nxt_ch[CH_W-1];
        end else begin : g_single
            assign nxt_sel = 1'b1;
        end
    endgenerate

    always_comb begin
        seq_d      = seq_q;
        seq_d.load = 1'b0;
        seq_d.done = 1'b0;
        restart    = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (expired) begin
                    restart     = 1'b1;
                    seq_d.state = ST_SETUP;
                    seq_d.ch    = nxt_ch;
                    seq_d.sel   = nxt_sel;
                    seq_d.code  = rd_code;
                    seq_d.load  = 1'b1;
                    seq_d.busy  = 1'b1;
                    seq_d.cnt   = WAIT_LD;
                end
            end
            ST_SETUP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state    = ST_SAMPLE;
                    seq_d.strobe_n = 1'b0;
                    seq_d.cnt      = SAMPLE_LD;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_SAMPLE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state    = ST_HOLD;
                    seq_d.strobe_n = 1'b1;
                    seq_d.cnt      = HOLD_LD;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else if (seq_q.ch == LAST_CH) begin
                    seq_d.state = ST_IDLE;
                    seq_d.busy  = 1'b0;
                    seq_d.done  = 1'b1;
                end else begin
                    seq_d.state = ST_SETUP;
                    seq_d.ch    = nxt_ch;
                    seq_d.sel   = nxt_sel;
                    seq_d.code  = rd_code;
                    seq_d.load  = 1'b1;
                    seq_d.cnt   = WAIT_LD;
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_chan    = nxt_ch;
    assign lock_en    = !seq_q.strobe_n;
    assign lock_chan  = seq_q.ch;
    assign dac_code   = seq_q.code;
    assign dac_load   = seq_q.load;
    assign ch_addr    = seq_q.ch[ADDR_W-1:0];
    assign bank_sel   = seq_q.sel;
    assign sample_n   = seq_q.strobe_n;
    assign busy       = seq_q.busy;
    assign sweep_done = seq_q.done;

endmodule

// File: rtl/shr_refresh_seq.sv
module shr_refresh_seq
    import shr_pkg::*;
#(
    parameter int CLK_KHZ    = 125000,
    parameter int SETUP_NS   = 50,
    parameter int HOLD_NS    = 150,
    parameter int GAP_NS     = 200,
    parameter int SAMPLE_NS  = 4000,
    parameter int SETTLE_NS  = 100,
    parameter int REFRESH_NS = 250000000,
    parameter int DAC_W      = 8,
    parameter int ADDR_W     = 5,
    parameter int DUAL_BANK  = 1,
    localparam int CH_W      = ADDR_W + ((DUAL_BANK != 0) ? 1 : 0)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [DAC_W-1:0]  wr_code,
    output logic [DAC_W-1:0]  dac_code,
    output logic              dac_load,
    output logic [ADDR_W-1:0] ch_addr,
    output logic              bank_sel,
    output logic              sample_n,
    output logic              busy,
    output logic              sweep_done
);

    localparam int NCH         = 1 << CH_W;
    localparam int SETUP_CYC   = ns2cyc(SETUP_NS, CLK_KHZ);
    localparam int HOLD_CYC    = ns2cyc(HOLD_NS, CLK_KHZ);
    localparam int GAP_CYC     = ns2cyc(GAP_NS, CLK_KHZ);
    localparam int SAMPLE_CYC  = ns2cyc(SAMPLE_NS, CLK_KHZ);
    localparam int SETTLE_CYC  = ns2cyc(SETTLE_NS, CLK_KHZ);
    localparam int REFRESH_CYC = ns2cyc(REFRESH_NS, CLK_KHZ);
    // address setup and DAC settling overlap; the rest of the gap is covered too
    localparam int WAIT_CYC    = max2(max2(SETUP_CYC, SETTLE_CYC),
                                      max2(GAP_CYC - HOLD_CYC, 1));

    logic              expired;
    logic              restart;
    logic              lock_en;
    logic [CH_W-1:0]   lock_chan;
    logic [CH_W-1:0]   rd_chan;
    logic [DAC_W-1:0]  rd_code;

    shr_regfile #(
        .NCH   (NCH),
        .CH_W  (CH_W),
        .DAC_W (DAC_W)
    ) i_regfile (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_chan   (wr_chan),
        .wr_code   (wr_code),
        .lock_en   (lock_en),
        .lock_chan (lock_chan),
        .rd_chan   (rd_chan),
        .rd_code   (rd_code)
    );

    shr_period_timer #(
        .PERIOD_CYC (REFRESH_CYC)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .expired (expired)
    );

    shr_sequencer #(
        .NCH        (NCH),
        .CH_W       (CH_W),
        .ADDR_W     (ADDR_W),
        .DAC_W      (DAC_W),
        .DUAL_BANK  (DUAL_BANK),
        .WAIT_CYC   (WAIT_CYC),
        .SAMPLE_CYC (SAMPLE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .expired    (expired),
        .rd_code    (rd_code),
        .rd_chan    (rd_chan),
        .restart    (restart),
        .lock_en    (lock_en),
        .lock_chan  (lock_chan),
        .dac_code   (dac_code),
        .dac_load   (dac_load),
        .ch_addr    (ch_addr),
        .bank_sel   (bank_sel),
        .sample_n   (sample_n),
        .busy       (busy),
        .sweep_done (sweep_done)
    );

endmodule

// File: rtl/shr_refresh_chk.sv
module shr_refresh_chk #(
    parameter int SETUP_CYC  = 7,
    parameter int HOLD_CYC   = 19,
    parameter int GAP_CYC    = 25,
    parameter int SAMPLE_CYC = 500,
    parameter int ADDR_W     = 5,
    parameter int DAC_W      = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_n,
    input logic              dac_load,
    input logic [DAC_W-1:0]  dac_code,
    input logic [ADDR_W-1:0] ch_addr,
    input logic              bank_sel,
    input logic              busy,
    input logic              sweep_done
);

    logic [ADDR_W:0] last_addr_q;
    logic            last_sn_q;
    logic [15:0]     addr_age_q, hi_age_q, lo_len_q;
    logic            chg;

    assign chg = ({bank_sel, ch_addr} != last_addr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr_q <= '0;
            last_sn_q   <= 1'b1;
            addr_age_q  <= '1;
            hi_age_q    <= '1;
            lo_len_q    <= '0;
        end else begin
            last_addr_q <= {bank_sel, ch_addr};
            last_sn_q   <= sample_n;
            addr_age_q  <= chg ? '0 : ((addr_age_q == '1) ? addr_age_q : addr_age_q + 1'b1);
            hi_age_q    <= (sample_n && !last_sn_q) ? '0 :
                           ((hi_age_q == '1) ? hi_age_q : hi_age_q + 1'b1);
            lo_len_q    <= (!sample_n && last_sn_q) ? '0 :
                           ((lo_len_q == '1) ? lo_len_q : lo_len_q + 1'b1);
        end
    end

    a_r3_addr_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(sample_n) |-> (!chg && (32'(addr_age_q) >= SETUP_CYC - 1)));

    a_r4_sample_len: assert property (@(posedge clk) disable iff (rst)
        $rose(sample_n) |-> (32'(lo_len_q) >= SAMPLE_CYC - 1));

    a_r5_addr_hold: assert property (@(posedge clk) disable iff (rst)
        chg |-> (sample_n && (32'(hi_age_q) >= HOLD_CYC - 1)));

    a_r6_gap_len: assert property (@(posedge clk) disable iff (rst)
        $fell(sample_n) |-> (32'(hi_age_q) >= GAP_CYC - 1));

    a_r7_no_load_in_sample: assert property (@(posedge clk) disable iff (rst)
        !sample_n |-> !dac_load);

    a_r7_code_steady: assert property (@(posedge clk) disable iff (rst)
        (!sample_n && !$past(sample_n)) |-> $stable(dac_code));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        sweep_done |=> !sweep_done);

    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        sweep_done |-> ($fell(busy) && sample_n));

endmodule

bind shr_refresh_seq shr_refresh_chk #(
    .SETUP_CYC  (SETUP_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .GAP_CYC    (GAP_CYC),
    .SAMPLE_CYC (SAMPLE_CYC),
    .ADDR_W     (ADDR_W),
    .DAC_W      (DAC_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_n   (sample_n),
    .dac_load   (dac_load),
    .dac_code   (dac_code),
    .ch_addr    (ch_addr),
    .bank_sel   (bank_sel),
    .busy       (busy),
    .sweep_done (sweep_done)
);

// File: tb/test_shr_refresh_seq.sv
module test_shr_refresh_seq;

    localparam int KHZ        = 125000;
    localparam int SAMPLE_NS  = 400;
    localparam int REFRESH_NS = 60000;
    localparam int NCH        = 64;
    // expected cycle limits, worked out by hand at 8 ns per cycle
    localparam int E_SETUP    = 7;
    localparam int E_HOLD     = 19;
    localparam int E_GAP      = 25;
    localparam int E_SAMPLE   = 50;
    localparam int E_SETTLE   = 13;
    localparam int E_REFRESH  = 7500;
    localparam int NVEC       = 8;
    localparam logic [13:0] VEC [NVEC] = '{
        {6'd0,  8'hA5}, {6'd1,  8'h5A}, {6'd31, 8'hFF}, {6'd32, 8'h01},
        {6'd33, 8'h80}, {6'd47, 8'h3C}, {6'd62, 8'hC3}, {6'd63, 8'h7E}
    };
    localparam int PARK_CH = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [5:0] wr_chan = '0;
    logic [7:0] wr_code = '0;
    logic [7:0] dac_code;
    logic       dac_load;
    logic [4:0] ch_addr;
    logic       bank_sel;
    logic       sample_n;
    logic       busy;
    logic       sweep_done;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_code [NCH];
    logic [7:0] seen_code [NCH];

    always #4 clk = ~clk;

    shr_refresh_seq #(
        .CLK_KHZ    (KHZ),
        .SAMPLE_NS  (SAMPLE_NS),
        .REFRESH_NS (REFRESH_NS)
    ) i_shr_refresh_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_chan    (wr_chan),
        .wr_code    (wr_code),
        .dac_code   (dac_code),
        .dac_load   (dac_load),
        .ch_addr    (ch_addr),
        .bank_sel   (bank_sel),
        .sample_n   (sample_n),
        .busy       (busy),
        .sweep_done (sweep_done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // ---------------- port monitor ----------------
    logic [5:0] prev_addr;
    logic       prev_sn, prev_busy, prev_done, code_moved;
    logic [7:0] code_at_fall;
    int addr_age, hi_age, lo_len, load_age, busy_age, next_ch;
    bit seen_busy;

    always @(negedge clk) begin
        if (rst) begin
            prev_addr = '0; prev_sn = 1'b1; prev_busy = 1'b0; prev_done = 1'b0;
            addr_age = 100000; hi_age = 100000; lo_len = 0; load_age = 100000;
            busy_age = 0; next_ch = 0; seen_busy = 0; code_moved = 0;
        end else begin
            addr_age = ({bank_sel, ch_addr} != prev_addr) ? 0 : addr_age + 1;
            hi_age   = (sample_n && !prev_sn) ? 0 : hi_age + 1;
            lo_len   = (!sample_n && prev_sn) ? 0 : lo_len + 1;
            load_age = dac_load ? 0 : load_age + 1;
            busy_age = busy_age + 1;
            if ({bank_sel, ch_addr} != prev_addr) begin
                check(sample_n && hi_age >= E_HOLD, "R5 addr hold after strobe rise", hi_age, E_HOLD);
            end
            if (dac_load) begin
                check(sample_n, "R7 load only in hold", sample_n, 1);
                check({bank_sel, ch_addr} == 6'(next_ch), "R2 channel order", {bank_sel, ch_addr}, next_ch);
                check(dac_code == exp_code[{bank_sel, ch_addr}], "R8 dac code",
                      dac_code, exp_code[{bank_sel, ch_addr}]);
                seen_code[{bank_sel, ch_addr}] = dac_code;
                next_ch = (next_ch + 1) % NCH;
            end
            if (!sample_n && prev_sn) begin
                check(addr_age >= E_SETUP, "R3 addr setup", addr_age, E_SETUP);
                check(load_age >= E_SETTLE, "R7 dac settle", load_age, E_SETTLE);
                check(hi_age >= E_GAP, "R6 strobe high gap", hi_age, E_GAP);
                code_at_fall = dac_code;
                code_moved = 0;
            end
            if (!sample_n && (dac_load || dac_code != code_at_fall)) code_moved = 1;
            if (sample_n && !prev_sn) begin
                check(lo_len >= E_SAMPLE, "R4 sample length", lo_len, E_SAMPLE);
                check(!code_moved, "R7 code steady while sampling", code_moved, 0);
            end
            if (busy && !prev_busy) begin
                if (seen_busy) check(busy_age == E_REFRESH, "R10 refresh period", busy_age, E_REFRESH);
                seen_busy = 1;
                busy_age = 0;
            end
            if (sweep_done) begin
                check(!busy && !prev_done && next_ch == 0, "R10 sweep done pulse", next_ch, 0);
            end
            prev_addr = {bank_sel, ch_addr};
            prev_sn   = sample_n;
            prev_busy = busy;
            prev_done = sweep_done;
        end
    end

    task automatic wait_done();
        @(negedge clk);
        while (!sweep_done) @(negedge clk);
    endtask

    task automatic host_write(input logic [5:0] ch, input logic [7:0] code);
        wr_en = 1'b1; wr_chan = ch; wr_code = code;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R10 watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            exp_code[i] = '0;
            seen_code[i] = '0;
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        check(sample_n == 1'b1, "R1 strobe in hold", sample_n, 1);
        check(bank_sel == 1'b0, "R1 select idle", bank_sel, 0);
        check(busy == 1'b0, "R1 busy low", busy, 0);
        check(dac_load == 1'b0, "R1 no load", dac_load, 0);
        check(sweep_done == 1'b0, "R1 no done", sweep_done, 0);
        rst = 1'b0;
        @(negedge clk);
        // R11: sweep starts on the first edge
        check(busy == 1'b1, "R11 busy at once", busy, 1);
        check(dac_load == 1'b1, "R11 load at once", dac_load, 1);
        check({bank_sel, ch_addr} == 6'd0, "R11 channel 0 first", {bank_sel, ch_addr}, 0);
        wait_done();
        // table walk: writes between sweeps
        for (int v = 0; v < NVEC; v++) begin
            host_write(VEC[v][13:8], VEC[v][7:0]);
            exp_code[VEC[v][13:8]] = VEC[v][7:0];
        end
        wait_done();
        for (int v = 0; v < NVEC; v++) begin
            check(seen_code[VEC[v][13:8]] == VEC[v][7:0], "R8 table code seen",
                  seen_code[VEC[v][13:8]], VEC[v][7:0]);
        end
        // R2: bank boundary 31 -> 32
        check(seen_code[31] == 8'hFF && seen_code[32] == 8'h01, "R2 bank select split",
              seen_code[32], 8'h01);
        // R9: double write aimed at the channel being sampled
        @(negedge clk);
        while (!(busy && !sample_n && {bank_sel, ch_addr} == 6'(PARK_CH))) @(negedge clk);
        host_write(6'(PARK_CH), 8'h11);
        host_write(6'(PARK_CH), 8'h99);
        check(sample_n == 1'b0, "R9 writes landed during sample", sample_n, 0);
        exp_code[PARK_CH] = 8'h99;
        wait_done();
        wait_done();
        check(seen_code[PARK_CH] == 8'h99, "R9 parked write kept", seen_code[PARK_CH], 8'h99);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule